// File: doc/BRIEF.md
# GPIO Pad Interrupt Event Controller

This block watches the receive path of a set of general-purpose pads and turns changes on them into sticky status bits that software can collect and acknowledge. Each pad is brought into the clock domain through a two-stage synchronizer. It is then optionally inverted and run through a detector whose behaviour a 2-bit event mode selects. Detected events are recorded in two status banks. The interrupt bank only records pads that the host owns, and an enable mask gates it onto one combined interrupt line. The wake bank is paired with a wake enable mask, and it only reaches the wake output for pads that are not routed to the system control interrupt path.

Pads are organised in groups of `GRP_SIZE` bits. The last group may be only partly populated, and its missing positions always read as zero. Per-pad configuration (event mode, invert, host ownership, routing) arrives as plain inputs from a neighbouring pad configuration block. Software reaches the four registers of each group through a small write port with a combinational read path.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: All status and enable registers, `irq_out` and `wake_out` are 0 after reset.
- R2: The event mode field of each pad (2 bits at positions 2p+1..2p of `pad_mode`) selects 0 = level, 1 = rising edge, 2 = disabled, 3 = any edge. In mode 3 both a rise and a fall set the status bit.
- R3: In level mode the status bit is set in every cycle in which the qualified input is 1. A clear that lands while the input is still asserted leaves the bit set.
- R4: In single-edge mode the status bit is set once per qualified 0-to-1 transition. After a clear it stays 0 while the input holds steady.
- R5: A pad in disabled mode never sets either status bit, whatever its input does.
- R6: Register kind is given by `reg_addr[1:0]`: 0 = interrupt status, 1 = interrupt enable, 2 = wake status, 3 = wake enable. The group is given by the upper address bits. Writing a 1 to a status bit clears it, a 0 leaves it unchanged, and writing all ones clears the whole group. Enable registers are plain read/write.
- R7: `irq_out` is 1 exactly when some pad has both its interrupt status bit and its interrupt enable bit set.
- R8: A pad whose `pad_host_own` bit is 0 never sets its interrupt status bit.
- R9: Bit positions at or beyond `NUM_PADS` read as 0 in every register and never drive either output.
- R10: `wake_out` is 1 exactly when some pad has its wake status bit set, its wake enable set and its `pad_route_sci` bit clear.
- R11: A detected event sets the pad's wake status bit regardless of host ownership. The bit is cleared by writing 1.
- R12: A pad input change applied before clock edge k is reflected in status (and `irq_out`) after edge k+2 and not earlier.
- R13: When `pad_inv` is 1, detection runs on the inverted input. Single-edge mode then reacts to falling edges and level mode to a low input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_in | input | NUM_PADS | Raw pad receive values, asynchronous |
| pad_mode | input | 2*NUM_PADS | Per-pad event mode, 2 bits per pad |
| pad_inv | input | NUM_PADS | Per-pad receive invert |
| pad_host_own | input | NUM_PADS | 1 = pad owned by host, 0 = firmware mode |
| pad_route_sci | input | NUM_PADS | 1 = pad routed to system control interrupt, blocks wake |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | GRP_W+2 | {group, register kind} |
| reg_wdata | input | GRP_SIZE | Write data |
| reg_rdata | output | GRP_SIZE | Combinational read data for reg_addr |
| irq_out | output | 1 | Combined interrupt |
| wake_out | output | 1 | Combined wake |

## Verification
Randomised trials pick a pad, a mode, an invert setting, ownership and a before/after input pair. They compare the resulting status bit with a model of the mode table. This separates level from edge behaviour, because a clear taken while a level input is high leaves the bit set. It separates rising from any-edge through falling-only transitions, and it shows the effect of the invert bit. Directed cases pin the synchronizer latency edge by edge and check partial write-one-to-clear masks. They also cover the half-populated last group, a firmware-owned pad, and the routing bit's effect on wake.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    typedef enum logic [1:0] {
        EVT_LEVEL = 2'd0,
        EVT_EDGE  = 2'd1,
        EVT_OFF   = 2'd2,
        EVT_BOTH  = 2'd3
    } evt_mode_e;

    typedef enum logic [1:0] {
        REG_ISTS = 2'd0,
        REG_IEN  = 2'd1,
        REG_WSTS = 2'd2,
        REG_WEN  = 2'd3
    } reg_kind_e;

    // qualified (post-invert) sample pair for one pad
    typedef struct packed {
        logic cur;
        logic prev;
    } pad_hist_t;

    function automatic logic evt_hit(evt_mode_e mode, pad_hist_t h);
        logic hit;
        case (mode)
            EVT_LEVEL: hit = h.cur;
            EVT_EDGE:  hit = h.cur & ~h.prev;
            EVT_BOTH:  hit = h.cur ^ h.prev;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

    function automatic int ceil_div(int a, int b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
    parameter int N = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pad_in,
    output logic [N-1:0] cur,
    output logic [N-1:0] prev
);
    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic [N-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign cur  = sync_q;
    assign prev = hist_q;
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
    import gpio_evt_pkg::*;
#(
    parameter int N = 20
) (
    input  logic [N-1:0]   cur,
    input  logic [N-1:0]   prev,
    input  logic [N-1:0]   inv,
    input  logic [2*N-1:0] mode,
    output logic [N-1:0]   evt
);
    for (genvar i = 0; i < N; i++) begin : g_pad
        pad_hist_t h;
        assign h.cur  = cur[i] ^ inv[i];
        assign h.prev = prev[i] ^ inv[i];
        assign evt[i] = evt_hit(evt_mode_e'(mode[2*i +: 2]), h);
    end
endmodule

// File: rtl/gpio_evt_w1c.sv
module gpio_evt_w1c #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] sts
);
    // a set in the same cycle as a clear wins
    always_ff @(posedge clk) begin
        if (rst) sts <= '0;
        else     sts <= (sts & ~clr) | set;
    end
endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
    import gpio_evt_pkg::*;
#(
    parameter int  NUM_PADS = 20,
    parameter int  GRP_SIZE = 16,
    localparam int NUM_GRPS = ceil_div(NUM_PADS, GRP_SIZE),
    localparam int GRP_W    = (NUM_GRPS > 1) ? $clog2(NUM_GRPS) : 1,
    localparam int ADDR_W   = GRP_W + 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PADS-1:0]   pad_in,
    input  logic [2*NUM_PADS-1:0] pad_mode,
    input  logic [NUM_PADS-1:0]   pad_inv,
    input  logic [NUM_PADS-1:0]   pad_host_own,
    input  logic [NUM_PADS-1:0]   pad_route_sci,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [GRP_SIZE-1:0]   reg_wdata,
    output logic [GRP_SIZE-1:0]   reg_rdata,
    output logic                  irq_out,
    output logic                  wake_out
);
    localparam int TOTAL = NUM_GRPS * GRP_SIZE;

    function automatic logic [TOTAL-1:0] mk_valid();
        logic [TOTAL-1:0] v;
        for (int i = 0; i < TOTAL; i++) v[i] = (i < NUM_PADS);
        return v;
    endfunction
    localparam logic [TOTAL-1:0] VALID = mk_valid();

    logic [NUM_PADS-1:0] s_cur, s_prev, evt;
    logic [TOTAL-1:0]    evt_ext, own_ext, sci_ext;
    logic [TOTAL-1:0]    ists_q, wsts_q, ien_q, wen_q;
    logic [TOTAL-1:0]    ists_clr, wsts_clr;
    logic [GRP_W-1:0]    a_grp;
    reg_kind_e           a_kind;

    assign a_grp  = reg_addr[ADDR_W-1:2];
    assign a_kind = reg_kind_e'(reg_addr[1:0]);

    gpio_evt_sync #(.N(NUM_PADS)) u_sync (
        .clk(clk), .rst(rst), .pad_in(pad_in), .cur(s_cur), .prev(s_prev)
    );

    gpio_evt_detect #(.N(NUM_PADS)) u_det (
        .cur(s_cur), .prev(s_prev), .inv(pad_inv), .mode(pad_mode), .evt(evt)
    );

    // widen per-pad vectors to the full group grid, absent positions tied low
    for (genvar i = 0; i < TOTAL; i++) begin : g_ext
        if (i < NUM_PADS) begin : g_real
            assign evt_ext[i] = evt[i];
            assign own_ext[i] = pad_host_own[i];
            assign sci_ext[i] = pad_route_sci[i];
        end else begin : g_absent
            assign evt_ext[i] = 1'b0;
            assign own_ext[i] = 1'b0;
            assign sci_ext[i] = 1'b0;
        end
    end

    always_comb begin
        ists_clr = '0;
        wsts_clr = '0;
        for (int g = 0; g < NUM_GRPS; g++) begin
            if (reg_wr && a_grp == GRP_W'(g)) begin
                if (a_kind == REG_ISTS) ists_clr[g*GRP_SIZE +: GRP_SIZE] = reg_wdata;
                if (a_kind == REG_WSTS) wsts_clr[g*GRP_SIZE +: GRP_SIZE] = reg_wdata;
            end
        end
    end

    gpio_evt_w1c #(.W(TOTAL)) u_ists (
        .clk(clk), .rst(rst),
        .set(evt_ext & own_ext & VALID), .clr(ists_clr), .sts(ists_q)
    );

    gpio_evt_w1c #(.W(TOTAL)) u_wsts (
        .clk(clk), .rst(rst),
        .set(evt_ext & VALID), .clr(wsts_clr), .sts(wsts_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q <= '0;
            wen_q <= '0;
        end else begin
            for (int g = 0; g < NUM_GRPS; g++) begin
                if (reg_wr && a_grp == GRP_W'(g)) begin
                    if (a_kind == REG_IEN)
                        ien_q[g*GRP_SIZE +: GRP_SIZE] <= reg_wdata & VALID[g*GRP_SIZE +: GRP_SIZE];
                    if (a_kind == REG_WEN)
                        wen_q[g*GRP_SIZE +: GRP_SIZE] <= reg_wdata & VALID[g*GRP_SIZE +: GRP_SIZE];
                end
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int g = 0; g < NUM_GRPS; g++) begin
            if (a_grp == GRP_W'(g)) begin
                case (a_kind)
                    REG_ISTS: reg_rdata = ists_q[g*GRP_SIZE +: GRP_SIZE];
                    REG_IEN:  reg_rdata = ien_q[g*GRP_SIZE +: GRP_SIZE];
                    REG_WSTS: reg_rdata = wsts_q[g*GRP_SIZE +: GRP_SIZE];
                    default:  reg_rdata = wen_q[g*GRP_SIZE +: GRP_SIZE];
                endcase
            end
        end
    end

    assign irq_out  = |(ists_q & ien_q);
    assign wake_out = |(wsts_q & wen_q & ~sci_ext);
endmodule

// File: rtl/gpio_evt_ctrl_chk.sv
module gpio_evt_ctrl_chk
    import gpio_evt_pkg::*;
#(
    parameter int  NUM_PADS = 20,
    parameter int  GRP_SIZE = 16,
    localparam int TOTAL    = ceil_div(NUM_PADS, GRP_SIZE) * GRP_SIZE
) (
    input logic                  clk,
    input logic                  rst,
    input logic [2*NUM_PADS-1:0] pad_mode,
    input logic [NUM_PADS-1:0]   pad_host_own,
    input logic                  irq_out,
    input logic                  wake_out,
    input logic [TOTAL-1:0]      ists,
    input logic [TOTAL-1:0]      wsts
);
    logic [TOTAL-1:0] own_ext, off_ext, valid;

    always_comb begin
        own_ext = '0;
        off_ext = '0;
        valid   = '0;
        for (int i = 0; i < NUM_PADS; i++) begin
            own_ext[i] = pad_host_own[i];
            off_ext[i] = (pad_mode[2*i +: 2] == 2'd2);
            valid[i]   = 1'b1;
        end
    end

    // R8
    fw_no_set_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((ists & ~$past(ists) & ~$past(own_ext)) == '0));

    // R5
    off_no_set_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((ists & ~$past(ists)) | (wsts & ~$past(wsts))) & $past(off_ext)) == '0);

    // R9
    absent_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((ists | wsts) & ~valid) == '0);

    // R7
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (ists != '0));

    // R10
    wake_src_chk: assert property (@(posedge clk) disable iff (rst)
        wake_out |-> (wsts != '0));
endmodule

bind gpio_evt_ctrl gpio_evt_ctrl_chk #(.NUM_PADS(NUM_PADS), .GRP_SIZE(GRP_SIZE)) u_chk (
    .clk(clk), .rst(rst), .pad_mode(pad_mode), .pad_host_own(pad_host_own),
    .irq_out(irq_out), .wake_out(wake_out), .ists(ists_q), .wsts(wsts_q)
);

// File: tb/gpio_evt_ctrl_tb.sv
module gpio_evt_ctrl_tb;
    localparam int NP = 20;
    localparam int GS = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pad_in = '0;
    logic [2*NP-1:0] pad_mode = {NP{2'd2}};
    logic [NP-1:0] pad_inv = '0;
    logic [NP-1:0] pad_host_own = '1;
    logic [NP-1:0] pad_route_sci = '0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [GS-1:0] reg_wdata = '0;
    logic [GS-1:0] reg_rdata;
    logic          irq_out, wake_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    gpio_evt_ctrl #(.NUM_PADS(NP), .GRP_SIZE(GS)) u_dut (
        .clk(clk), .rst(rst), .pad_in(pad_in), .pad_mode(pad_mode),
        .pad_inv(pad_inv), .pad_host_own(pad_host_own), .pad_route_sci(pad_route_sci),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out), .wake_out(wake_out)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int grp, int kind, logic [GS-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = {grp[0], kind[1:0]}; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(int grp, int kind, output logic [GS-1:0] v);
        reg_addr = {grp[0], kind[1:0]};
        #1;
        v = reg_rdata;
    endtask

    task automatic cfg(int p, logic [1:0] m, logic iv, logic own);
        pad_mode[2*p +: 2] = m;
        pad_inv[p] = iv;
        pad_host_own[p] = own;
    endtask

    task automatic clear_all();
        wr(0, 0, '1); wr(1, 0, '1); wr(0, 2, '1); wr(1, 2, '1);
    endtask

    function automatic logic exp_bit(logic [1:0] m, logic iv, logic own, logic v0, logic v1);
        logic q0, q1, r;
        q0 = v0 ^ iv;
        q1 = v1 ^ iv;
        case (m)
            2'd0: r = q0 | q1;
            2'd1: r = ~q0 & q1;
            2'd3: r = q0 ^ q1;
            default: r = 1'b0;
        endcase
        return r & own;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [GS-1:0] v;
        void'($urandom(32'h5EED_1234));
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        for (int k = 0; k < 4; k++) begin
            rd(0, k, v); chk("R1 reset reg g0", 32'(v), 0);
        end
        chk("R1 irq reset", 32'(irq_out), 0);
        chk("R1 wake reset", 32'(wake_out), 0);

        // R12 latency, edge mode on pad 0
        cfg(0, 2'd1, 1'b0, 1'b1);
        idle(5);
        clear_all();
        wr(0, 1, 16'h0001);
        @(negedge clk); pad_in[0] = 1'b1;
        @(negedge clk); chk("R12 after edge k", 32'(irq_out), 0);
        @(negedge clk); chk("R12 after edge k+1", 32'(irq_out), 0);
        @(negedge clk); chk("R12 after edge k+2", 32'(irq_out), 1);
        rd(0, 0, v); chk("R12 status bit", 32'(v[0]), 1);

        // R4 edge: no re-set while held high
        wr(0, 0, 16'h0001); idle(3);
        rd(0, 0, v); chk("R4 edge stays clear", 32'(v[0]), 0);
        chk("R7 irq low after clear", 32'(irq_out), 0);

        // R3 level re-sets while asserted
        cfg(0, 2'd0, 1'b0, 1'b1); idle(4);
        wr(0, 0, 16'h0001);
        rd(0, 0, v); chk("R3 level re-set", 32'(v[0]), 1);

        // R13 falling edge via invert
        cfg(0, 2'd1, 1'b1, 1'b1); idle(5);
        clear_all();
        @(negedge clk); pad_in[0] = 1'b0; idle(4);
        rd(0, 0, v); chk("R13 falling edge", 32'(v[0]), 1);

        // R13 active-low level, then input high clears for good
        cfg(0, 2'd0, 1'b1, 1'b1); pad_in[0] = 1'b1; idle(5);
        clear_all(); idle(2);
        rd(0, 0, v); chk("R13 low level inactive when high", 32'(v[0]), 0);

        // R5 disabled mode
        cfg(0, 2'd2, 1'b0, 1'b1);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); pad_in[0] = ~pad_in[0];
        end
        idle(4);
        rd(0, 0, v); chk("R5 disabled int", 32'(v[0]), 0);
        rd(0, 2, v); chk("R5 disabled wake", 32'(v[0]), 0);

        // R6 / R2 partial write-one-to-clear, any-edge mode on pads 0..3
        wr(0, 1, 16'h0000);
        for (int p = 0; p < 4; p++) cfg(p, 2'd3, 1'b0, 1'b1);
        pad_in[3:0] = 4'b0000; idle(5); clear_all();
        @(negedge clk); pad_in[3:0] = 4'b1111; idle(4);
        wr(0, 0, 16'h0000);
        rd(0, 0, v); chk("R6 write zero keeps", 32'(v), 32'h000F);
        wr(0, 0, 16'h0005);
        rd(0, 0, v); chk("R6 partial clear", 32'(v), 32'h000A);
        wr(0, 0, 16'hFFFF);
        rd(0, 0, v); chk("R6 group clear", 32'(v), 0);
        @(negedge clk); pad_in[3:0] = 4'b0000; idle(4);
        rd(0, 0, v); chk("R2 any-edge falling", 32'(v), 32'h000F);

        // R7 enable gating
        chk("R7 no enable no irq", 32'(irq_out), 0);
        wr(0, 1, 16'h0004);
        chk("R7 enabled irq", 32'(irq_out), 1);
        wr(0, 0, 16'hFFFF); wr(0, 1, 16'h0000);
        for (int p = 0; p < 4; p++) cfg(p, 2'd2, 1'b0, 1'b1);

        // R8 firmware-owned pad
        cfg(2, 2'd0, 1'b0, 1'b0);
        wr(0, 1, 16'hFFFF);
        @(negedge clk); pad_in[2] = 1'b1; idle(5);
        rd(0, 0, v); chk("R8 firmware pad no status", 32'(v[2]), 0);
        chk("R8 firmware pad no irq", 32'(irq_out), 0);
        // R11 wake bit still set by firmware pad event
        rd(0, 2, v); chk("R11 wake set regardless of owner", 32'(v[2]), 1);
        cfg(2, 2'd2, 1'b0, 1'b1); pad_in[2] = 1'b0;
        wr(0, 1, 16'h0000); clear_all();

        // R9 partial last group
        wr(1, 1, 16'hFFFF);
        rd(1, 1, v); chk("R9 enable absent bits", 32'(v), 32'h000F);
        for (int p = 0; p < NP; p++) cfg(p, 2'd0, 1'b0, 1'b1);
        @(negedge clk); pad_in = '1; idle(5);
        rd(1, 0, v); chk("R9 status absent bits", 32'(v), 32'h000F);
        rd(1, 2, v); chk("R9 wake absent bits", 32'(v), 32'h000F);
        chk("R9 irq from real bits", 32'(irq_out), 1);
        pad_mode = {NP{2'd2}}; pad_in = '0;
        wr(1, 1, 16'h0000); idle(4); clear_all();

        // R10 / R11 wake path on pad 5
        cfg(5, 2'd1, 1'b0, 1'b1);
        @(negedge clk); pad_in[5] = 1'b1; idle(4);
        rd(0, 2, v); chk("R11 wake status set", 32'(v[5]), 1);
        chk("R10 no wake without enable", 32'(wake_out), 0);
        wr(0, 3, 16'h0020);
        chk("R10 wake enabled", 32'(wake_out), 1);
        @(negedge clk); pad_route_sci[5] = 1'b1; #1;
        chk("R10 sci routing blocks wake", 32'(wake_out), 0);
        @(negedge clk); pad_route_sci[5] = 1'b0; #1;
        chk("R10 wake back", 32'(wake_out), 1);
        wr(0, 2, 16'h0020);
        rd(0, 2, v); chk("R11 wake w1c", 32'(v[5]), 0);
        chk("R10 wake after clear", 32'(wake_out), 0);
        cfg(5, 2'd2, 1'b0, 1'b1); pad_in[5] = 1'b0; wr(0, 3, 16'h0000);

        // R2 random trials over mode, invert, ownership and input step
        for (int t = 0; t < 60; t++) begin
            int p;
            logic [1:0] m;
            logic iv, own, v0, v1, e;
            p   = $urandom_range(0, NP-1);
            m   = 2'($urandom_range(0, 3));
            iv  = 1'($urandom_range(0, 1));
            own = 1'($urandom_range(0, 1));
            v0  = 1'($urandom_range(0, 1));
            v1  = 1'($urandom_range(0, 1));
            @(negedge clk);
            cfg(p, m, iv, own);
            pad_in[p] = v0;
            idle(5);
            wr(p / GS, 0, '1);
            pad_in[p] = v1;
            idle(5);
            rd(p / GS, 0, v);
            e = exp_bit(m, iv, own, v0, v1);
            chk($sformatf("R2 random pad %0d mode %0d inv %0d own %0d", p, m, iv, own),
                32'(v[p % GS]), 32'(e));
            cfg(p, 2'd2, 1'b0, 1'b1);
            pad_in[p] = 1'b0;
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule